// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA

This block feeds a transmit FIFO from host memory by following a chain of transmit descriptors. A host start pulse hands it the address of the first descriptor. A separate input gives the address of the last one. For each descriptor the engine fetches the next-pointer word, the data-pointer word and the control word, in that order. It then copies the data section into the FIFO one word at a time, in bursts, and only while the FIFO asks for data. When the section is done, it marks the descriptor complete in memory and moves on to the next descriptor in the chain.

Data sections may start at any byte address. The memory port always reads whole 32-bit words, and a per-byte valid mask sent with each FIFO word tells the serial controller which lanes carry payload. A frame-end flag travels with the last data word of a section, and the completion of such a descriptor also pulses a frame interrupt. The engine stops with an error pulse when a descriptor that does not end a frame is either held or is the last one in the chain.

Descriptor layout, as word offsets from the descriptor base:

| Offset | Contents |
|---|---|
| +0 | next pointer |
| +4 | data pointer |
| +8 | length in bits [15:0], hold in bit 30, frame-end in bit 31 |
| +12 | status, with the complete flag in bit 31 |
| +16, +20 | spare, never accessed by the engine |

Top module: `tx_chain_dma`

## Requirements
- R1: After a start pulse the engine reads the descriptor at `first_desc` at offsets +0, +4 and +8, in that order, before any data word is read.
- R2: Every memory read has all four byte enables set and is a whole aligned 32-bit word.
- R3: A burst moves at most BURST_WORDS data words. A new burst begins only at a burst boundary where `fifo_req` is high, and bursts repeat until the section is exhausted.
- R4: In the first word of a section, byte lanes below the data pointer's low two bits are cleared in `fifo_bmask`, where bit k marks byte k, bits [8k+7:8k].
- R5: The number of words moved is ceil((offset+length)/4). In the last word, only lanes below (offset+length) mod 4 are valid, and a result of 0 means all four lanes are valid. Each data word equals the memory word at that aligned address.
- R6: A zero-length descriptor produces no FIFO writes but is still marked complete.
- R7: After its data section, each descriptor gets one write to base+12 with bit 31 set and all byte enables set.
- R8: After completion, the engine follows the next pointer unless the descriptor base equals `last_desc`. In that case it returns to idle with `busy` low. `busy` is low after reset.
- R9: `fifo_fend` is set only on the last data word of a frame-end descriptor. `irq_frame` pulses on the cycle after that descriptor's completion write is accepted.
- R10: A control word with frame-end clear and hold set raises `irq_err` on the cycle after it is read. The engine then goes idle with no data moved and no completion write.
- R11: A control word with frame-end clear, read from the descriptor at `last_desc`, raises `irq_err` and stops the engine in the same way.
- R12: `irq_frame` and `irq_err` are never high for two cycles in a row.
- R13: The two spare descriptor words at base+16 and base+20 are never read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | one-cycle pulse that begins a chain walk |
| first_desc | input | 32 | address of the first descriptor |
| last_desc | input | 32 | address of the last descriptor |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | word-aligned byte address |
| mem_be | output | 4 | byte enables |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid when mem_ready is high |
| mem_ready | input | 1 | access accepted on this edge |
| fifo_req | input | 1 | FIFO asks for another burst |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write word |
| fifo_bmask | output | 4 | valid byte lanes of fifo_data |
| fifo_fend | output | 1 | last word of a frame |
| irq_frame | output | 1 | frame-end descriptor completed |
| irq_err | output | 1 | chain stopped on an error |
| busy | output | 1 | engine is walking a chain |

## Verification
Each result has a fixed delay after the edge where its memory access is accepted. A data word reaches the FIFO port one cycle after its read is accepted. `irq_frame` appears one cycle after the completion write is accepted, and `irq_err` one cycle after the control-word read is accepted. The bench's memory model grants accesses on the falling edge and records the cycle number of each grant. It then compares the interrupt cycles against those grant cycles plus one, and logs FIFO words at the same falling-edge sample point. To check burst gating, the bench holds `fifo_req` low for a long wait, then raises it across exactly one rising edge and counts the words that follow.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int LANES     = 4;
  localparam int FE_BIT    = 31;
  localparam int HOLD_BIT  = 30;
  localparam int DONE_BIT  = 31;
  localparam int OFS_NEXT  = 0;
  localparam int OFS_DATA  = 4;
  localparam int OFS_CTRL  = 8;
  localparam int OFS_STAT  = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_DPTR, S_CTRL, S_WAIT, S_BURST, S_DONE
  } tcd_state_e;

  // number of whole words touched by a section
  function automatic logic [31:0] span_words(input logic [1:0] off, input logic [31:0] len);
    if (len == 32'd0) return 32'd0;
    return (len + {30'd0, off} + 32'd3) >> 2;
  endfunction

  // lanes at or above the start offset
  function automatic logic [3:0] lead_mask(input logic [1:0] off);
    return 4'(4'hF << off);
  endfunction

  // lanes below the end offset; zero means the word is full
  function automatic logic [3:0] tail_mask(input logic [1:0] end_off);
    if (end_off == 2'd0) return 4'hF;
    return 4'(~(4'hF << end_off));
  endfunction
endpackage

// File: rtl/tcd_span_calc.sv
module tcd_span_calc
  import tcd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int WC_W  = LEN_W + 1
) (
  input  logic [AW-1:0]    dptr,
  input  logic [LEN_W-1:0] len,
  output logic [WC_W-1:0]  words,
  output logic [3:0]       lead,
  output logic [3:0]       tail,
  output logic [AW-1:0]    wbase
);
  logic [1:0] end_off;

  assign end_off = dptr[1:0] + len[1:0];
  assign words   = WC_W'(span_words(dptr[1:0], 32'(len)));
  assign lead    = lead_mask(dptr[1:0]);
  assign tail    = tail_mask(end_off);
  assign wbase   = {dptr[AW-1:2], 2'b00};
endmodule

// File: rtl/tcd_burst_ctr.sv
module tcd_burst_ctr #(
  parameter int BURST_WORDS = 4,
  localparam int CW = $clog2(BURST_WORDS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= CW'(BURST_WORDS);
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/tcd_fifo_stage.sv
module tcd_fifo_stage
  import tcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic [31:0] data_in,
  input  logic [3:0]  mask_in,
  input  logic        fend_in,
  output logic        fifo_wr,
  output logic [31:0] fifo_data,
  output logic [3:0]  fifo_bmask,
  output logic        fifo_fend
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    logic       vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= beat & mask_in[g];
        if (beat) byte_q <= data_in[8*g +: 8];
      end
    end
    assign fifo_data[8*g +: 8] = byte_q;
    assign fifo_bmask[g]       = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_fend <= 1'b0;
    end else begin
      fifo_wr   <= beat;
      fifo_fend <= beat & fend_in;
    end
  end
endmodule

// File: rtl/tx_chain_dma.sv
module tx_chain_dma
  import tcd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_desc,
  input  logic [AW-1:0] last_desc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          fifo_req,
  output logic          fifo_wr,
  output logic [31:0]   fifo_data,
  output logic [3:0]    fifo_bmask,
  output logic          fifo_fend,
  output logic          irq_frame,
  output logic          irq_err,
  output logic          busy
);
  localparam int WC_W = LEN_W + 1;

  tcd_state_e st, st_n;

  logic [AW-1:0]   cur, nxt, dptr_q, last_q, waddr;
  logic [WC_W-1:0] words_left;
  logic [3:0]      lead_q, tail_q;
  logic            first_q, fe_q;
  logic            irq_f_q, irq_e_q;

  // named events
  logic            hs, beat, burst_load, burst_last, burst_end;
  logic            end_of_sect, wb_hs, err_hit, list_end, ctrl_ok;
  logic [LEN_W-1:0] len_in;
  logic            fe_in, hold_in;
  logic [WC_W-1:0] span_w;
  logic [3:0]      span_lead, span_tail, beat_mask;
  logic [AW-1:0]   span_base;

  assign len_in  = mem_rdata[LEN_W-1:0];
  assign fe_in   = mem_rdata[FE_BIT];
  assign hold_in = mem_rdata[HOLD_BIT];

  tcd_span_calc #(.AW(AW), .LEN_W(LEN_W), .WC_W(WC_W)) u_span (
    .dptr  (dptr_q),
    .len   (len_in),
    .words (span_w),
    .lead  (span_lead),
    .tail  (span_tail),
    .wbase (span_base)
  );

  // memory master drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_NEXT:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_NEXT); end
      S_DPTR:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_DATA); end
      S_CTRL:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_CTRL); end
      S_BURST: begin mem_req = 1'b1; mem_addr = waddr; end
      S_DONE:  begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(OFS_STAT);
        mem_wdata = 32'(1) << DONE_BIT;
      end
      default: ;
    endcase
  end
  assign mem_be = 4'hF;

  assign hs          = mem_req & mem_ready;
  assign end_of_sect = (words_left == WC_W'(1));
  assign beat        = (st == S_BURST) & hs;
  assign burst_load  = (st == S_WAIT) & (words_left != '0) & fifo_req;
  assign burst_end   = beat & (burst_last | end_of_sect);
  assign wb_hs       = (st == S_DONE) & hs;
  assign list_end    = wb_hs & (cur == last_q);
  assign err_hit     = (st == S_CTRL) & hs & ~fe_in & (hold_in | (cur == last_q));
  assign ctrl_ok     = (st == S_CTRL) & hs & ~err_hit;
  assign beat_mask   = (first_q ? lead_q : 4'hF) & (end_of_sect ? tail_q : 4'hF);

  tcd_burst_ctr #(.BURST_WORDS(BURST_WORDS)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (burst_load),
    .dec   (beat),
    .last  (burst_last)
  );

  tcd_fifo_stage u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .data_in    (mem_rdata),
    .mask_in    (beat_mask),
    .fend_in    (fe_q & end_of_sect),
    .fifo_wr    (fifo_wr),
    .fifo_data  (fifo_data),
    .fifo_bmask (fifo_bmask),
    .fifo_fend  (fifo_fend)
  );

  // next state
  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (start) st_n = S_NEXT;
      S_NEXT:  if (hs) st_n = S_DPTR;
      S_DPTR:  if (hs) st_n = S_CTRL;
      S_CTRL:  if (err_hit) st_n = S_IDLE; else if (hs) st_n = S_WAIT;
      S_WAIT:  if (words_left == '0) st_n = S_DONE; else if (fifo_req) st_n = S_BURST;
      S_BURST: if (burst_end) st_n = S_WAIT;
      S_DONE:  if (list_end) st_n = S_IDLE; else if (hs) st_n = S_NEXT;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur        <= '0;
      nxt        <= '0;
      dptr_q     <= '0;
      last_q     <= '0;
      waddr      <= '0;
      words_left <= '0;
      lead_q     <= 4'hF;
      tail_q     <= 4'hF;
      first_q    <= 1'b0;
      fe_q       <= 1'b0;
      irq_f_q    <= 1'b0;
      irq_e_q    <= 1'b0;
    end else begin
      st      <= st_n;
      irq_f_q <= wb_hs & fe_q;
      irq_e_q <= err_hit;
      if ((st == S_IDLE) && start) begin
        cur    <= first_desc;
        last_q <= last_desc;
      end
      if ((st == S_NEXT) && hs) nxt    <= mem_rdata[AW-1:0];
      if ((st == S_DPTR) && hs) dptr_q <= mem_rdata[AW-1:0];
      if (ctrl_ok) begin
        words_left <= span_w;
        waddr      <= span_base;
        lead_q     <= span_lead;
        tail_q     <= span_tail;
        first_q    <= 1'b1;
        fe_q       <= fe_in;
      end
      if (beat) begin
        words_left <= words_left - 1'b1;
        waddr      <= waddr + AW'(4);
        first_q    <= 1'b0;
      end
      if (wb_hs && !list_end) cur <= nxt;
    end
  end

  assign irq_frame = irq_f_q;
  assign irq_err   = irq_e_q;
  assign busy      = (st != S_IDLE);
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker #(
  parameter int AW          = 32,
  parameter int BURST_WORDS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          fifo_wr,
  input logic [3:0]    fifo_bmask,
  input logic          irq_frame,
  input logic          irq_err,
  input logic          beat,
  input logic          burst_load,
  input logic          wb_hs
);
  localparam int CW = $clog2(BURST_WORDS + 1);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bcnt <= '0;
    else if (burst_load) bcnt <= '0;
    else if (beat)       bcnt <= bcnt + 1'b1;
  end

  // R2: whole-word reads only
  p_full_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == 4'hF && mem_addr[1:0] == 2'b00));

  // R2: request held with a stable address until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R3: burst cap
  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (bcnt < CW'(BURST_WORDS)));

  // R4: a FIFO word always carries at least one valid lane
  p_mask_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_bmask != 4'h0));

  // R7: writes only set the complete flag with all enables
  p_done_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[31] && mem_be == 4'hF));

  // R9: frame interrupt follows an accepted completion write
  p_frame_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_frame) |-> $past(wb_hs));

  // R10: after an error the engine has stopped
  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !mem_req);

  // R12: single-cycle interrupts
  p_frame_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |=> !irq_frame);
  p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |=> !irq_err);
endmodule

bind tx_chain_dma tcd_checker #(.AW(AW), .BURST_WORDS(BURST_WORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .fifo_wr    (fifo_wr),
  .fifo_bmask (fifo_bmask),
  .irq_frame  (irq_frame),
  .irq_err    (irq_err),
  .beat       (beat),
  .burst_load (burst_load),
  .wb_hs      (wb_hs)
);

// File: tb/sim_tx_chain_dma.sv
`timescale 1ns/1ps
module sim_tx_chain_dma;
  localparam int BW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_desc = '0, last_desc = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        fifo_req = 1'b0;
  logic        fifo_wr, fifo_fend, irq_frame, irq_err, busy;
  logic [31:0] fifo_data;
  logic [3:0]  fifo_bmask;

  always #10 clk = ~clk;

  tx_chain_dma #(.BURST_WORDS(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_desc(first_desc), .last_desc(last_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .fifo_req(fifo_req), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_bmask(fifo_bmask),
    .fifo_fend(fifo_fend), .irq_frame(irq_frame), .irq_err(irq_err), .busy(busy)
  );

  int ntests = 0, nfail = 0;
  logic [31:0] mem [0:255];
  bit          touched [0:255];
  logic [31:0] log_data [0:63];
  logic [3:0]  log_mask [0:63];
  bit          log_fend [0:63];
  logic [31:0] rd_log [0:63];
  logic [31:0] wb_log [0:15];
  int nbeats, nrd, nwb, nirqf, nirqe, longp, be_bad;
  int cyc = 0, wb_cyc, rd_cyc, irqf_cyc, irqe_cyc;
  bit stall_en = 1'b0, waited = 1'b0, irqf_prev = 1'b0, irqe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model and output monitor on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (fifo_wr && nbeats < 64) begin
      log_data[nbeats] = fifo_data; log_mask[nbeats] = fifo_bmask;
      log_fend[nbeats] = fifo_fend; nbeats++;
    end
    if (irq_frame) begin nirqf++; irqf_cyc = cyc; if (irqf_prev) longp++; end
    if (irq_err)   begin nirqe++; irqe_cyc = cyc; if (irqe_prev) longp++; end
    irqf_prev = irq_frame;
    irqe_prev = irq_err;
    if (mem_req && (!stall_en || waited)) begin
      mem_ready = 1'b1;
      waited = 1'b0;
      touched[mem_addr[9:2]] = 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (nwb < 16) wb_log[nwb] = mem_addr;
        nwb++; wb_cyc = cyc;
      end else begin
        if (mem_be != 4'hF) be_bad++;
        mem_rdata = mem[mem_addr[9:2]];
        if (nrd < 64) rd_log[nrd] = mem_addr;
        nrd++; rd_cyc = cyc;
      end
    end else begin
      mem_ready = 1'b0;
      waited = mem_req;
    end
  end

  task automatic clear_logs();
    nbeats = 0; nrd = 0; nwb = 0; nirqf = 0; nirqe = 0; longp = 0; be_bad = 0;
    wb_cyc = -1; rd_cyc = -1; irqf_cyc = -9; irqe_cyc = -9;
    for (int i = 0; i < 256; i++) touched[i] = 1'b0;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'h5A3C_0000;
  endtask

  task automatic set_desc(input int base, input int nxt, input int dptr, input int len,
                          input bit fe, input bit hold);
    mem[base/4]     = 32'(nxt);
    mem[base/4 + 1] = 32'(dptr);
    mem[base/4 + 2] = {fe, hold, 14'd0, 16'(len)};
    mem[base/4 + 3] = 32'h0;
    mem[base/4 + 4] = 32'hDEAD_0004;
    mem[base/4 + 5] = 32'hDEAD_0005;
  endtask

  task automatic kick(input int f, input int l);
    @(negedge clk);
    first_desc = 32'(f); last_desc = 32'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(!busy, req, 32'(busy), 32'h0);
  endtask

  // expected words of one data section, derived byte by byte
  task automatic chk_section(input int dptr, input int len, input bit fe, inout int bi);
    int fw, lw;
    logic [3:0] m;
    if (len == 0) return;
    fw = dptr & ~3;
    lw = (dptr + len - 1) & ~3;
    for (int wa = fw; wa <= lw; wa += 4) begin
      m = '0;
      for (int k = 0; k < 4; k++) if (wa + k >= dptr && wa + k < dptr + len) m[k] = 1'b1;
      chk(log_mask[bi] == m, "R4/R5 mask", 32'(log_mask[bi]), 32'(m));
      chk(log_data[bi] == mem[wa/4], "R5 data", log_data[bi], mem[wa/4]);
      chk(log_fend[bi] == (fe && wa == lw), "R9 fend", 32'(log_fend[bi]), 32'(fe && wa == lw));
      bi++;
    end
  endtask

  task automatic chk_spare(input int base);
    chk(!touched[base/4 + 4] && !touched[base/4 + 5], "R13 spare words",
        {31'd0, touched[base/4 + 4] | touched[base/4 + 5]}, 32'h0);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req && !fifo_wr, "R8 reset idle", {29'd0, busy, mem_req, fifo_wr}, 32'h0);
    chk(!irq_frame && !irq_err, "R12 reset irq", {30'd0, irq_frame, irq_err}, 32'h0);
  endtask

  task automatic t_single_aligned();
    int bi = 0;
    clear_logs(); fill_mem(); fifo_req = 1'b1; stall_en = 1'b0;
    set_desc('h000, 'h040, 'h200, 20, 1'b1, 1'b0);
    kick('h000, 'h000);
    wait_idle("R8 single");
    chk(rd_log[0] == 32'h000 && rd_log[1] == 32'h004 && rd_log[2] == 32'h008, "R1 order",
        rd_log[2], 32'h008);
    chk(be_bad == 0, "R2 byte enables", 32'(be_bad), 32'h0);
    chk(nbeats == 5, "R5 word count", 32'(nbeats), 32'd5);
    chk_section('h200, 20, 1'b1, bi);
    chk(nwb == 1 && wb_log[0] == 32'h00C, "R7 status address", wb_log[0], 32'h00C);
    chk(mem['h00C/4] == 32'h8000_0000, "R7 complete flag", mem['h00C/4], 32'h8000_0000);
    chk(nirqf == 1 && irqf_cyc == wb_cyc + 1, "R9 irq_frame timing", 32'(irqf_cyc - wb_cyc), 32'd1);
    chk(nrd == 8, "R8 no walk past last", 32'(nrd), 32'd8);
    chk(longp == 0, "R12 pulse width", 32'(longp), 32'h0);
    chk_spare('h000);
  endtask

  task automatic t_chain_unaligned();
    int bi = 0;
    clear_logs(); fill_mem(); fifo_req = 1'b1; stall_en = 1'b1;
    set_desc('h000, 'h040, 'h201, 6, 1'b0, 1'b0);
    set_desc('h040, 'h080, 'h303, 1, 1'b0, 1'b0);
    set_desc('h080, 'h0C0, 'h382, 0, 1'b1, 1'b0);
    kick('h000, 'h080);
    wait_idle("R8 chain");
    chk(nbeats == 3, "R5 chain word count", 32'(nbeats), 32'd3);
    chk_section('h201, 6, 1'b0, bi);
    chk_section('h303, 1, 1'b0, bi);
    chk(nwb == 3 && wb_log[1] == 32'h04C && wb_log[2] == 32'h08C, "R8 follows next", wb_log[2], 32'h08C);
    chk(mem['h08C/4] == 32'h8000_0000, "R6 zero length completed", mem['h08C/4], 32'h8000_0000);
    chk(nirqf == 1 && irqf_cyc == wb_cyc + 1, "R9 frame irq on zero length", 32'(nirqf), 32'd1);
    chk(be_bad == 0, "R2 byte enables stalled", 32'(be_bad), 32'h0);
    chk_spare('h000); chk_spare('h040); chk_spare('h080);
    chk(longp == 0, "R12 pulse width chain", 32'(longp), 32'h0);
  endtask

  task automatic t_burst_gate();
    int bi = 0;
    clear_logs(); fill_mem(); fifo_req = 1'b0; stall_en = 1'b0;
    set_desc('h000, 'h000, 'h200, 40, 1'b1, 1'b0);
    kick('h000, 'h000);
    repeat (30) @(negedge clk);
    chk(nbeats == 0, "R3 no request no data", 32'(nbeats), 32'h0);
    fifo_req = 1'b1; @(negedge clk); fifo_req = 1'b0;
    repeat (30) @(negedge clk);
    chk(nbeats == BW, "R3 one burst", 32'(nbeats), 32'(BW));
    fifo_req = 1'b1; @(negedge clk); fifo_req = 1'b0;
    repeat (30) @(negedge clk);
    chk(nbeats == 2 * BW, "R3 second burst", 32'(nbeats), 32'(2 * BW));
    fifo_req = 1'b1;
    wait_idle("R8 gated");
    chk(nbeats == 10, "R3 remainder", 32'(nbeats), 32'd10);
    chk_section('h200, 40, 1'b1, bi);
  endtask

  task automatic t_err_hold();
    clear_logs(); fill_mem(); fifo_req = 1'b1; stall_en = 1'b0;
    set_desc('h140, 'h180, 'h200, 12, 1'b0, 1'b1);
    kick('h140, 'h180);
    wait_idle("R10 idle after hold error");
    chk(nirqe == 1 && irqe_cyc == rd_cyc + 1, "R10 irq_err timing", 32'(irqe_cyc - rd_cyc), 32'd1);
    chk(nbeats == 0 && nwb == 0, "R10 nothing moved", 32'(nbeats + nwb), 32'h0);
    chk(nirqf == 0 && longp == 0, "R12 err pulse", 32'(nirqf + longp), 32'h0);
  endtask

  task automatic t_err_last();
    int bi = 0;
    clear_logs(); fill_mem(); fifo_req = 1'b1; stall_en = 1'b1;
    set_desc('h0C0, 'h100, 'h280, 8, 1'b1, 1'b0);
    set_desc('h100, 'h140, 'h2C0, 8, 1'b0, 1'b0);
    kick('h0C0, 'h100);
    wait_idle("R11 idle after last error");
    chk(nbeats == 2, "R11 only first section", 32'(nbeats), 32'd2);
    chk_section('h280, 8, 1'b1, bi);
    chk(nwb == 1 && wb_log[0] == 32'h0CC, "R11 one completion", 32'(nwb), 32'd1);
    chk(mem['h10C/4] == 32'h0, "R11 last not completed", mem['h10C/4], 32'h0);
    chk(nirqe == 1 && irqe_cyc == rd_cyc + 1, "R11 irq_err", 32'(nirqe), 32'd1);
    chk(nirqf == 1, "R9 frame irq before error", 32'(nirqf), 32'd1);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        nfail++; ntests++;
        $display("FAIL watchdog act=%0d exp=finish", wd);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
      end
    end
  end

  initial begin
    clear_logs(); fill_mem();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single_aligned();
    t_chain_unaligned();
    t_burst_gate();
    t_err_hold();
    t_err_last();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule